// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the write-side command interpreter of a parallel NOR flash array that runs in 16-bit word mode. Each cycle with `wr_en` high is a bus write carrying an address and a data word. The decoder follows the multi-write unlock handshakes, in which both the address and the data must match. It keeps track of the operating mode the array is in: read array, identification (autoselect), unlock bypass, secured region, CFI query, erase-suspended read, or identification while suspended. It recognises the program, chip erase, sector erase, suspend and resume commands.

For each accepted operation it raises `req_valid` for exactly one cycle. In that cycle it presents an operation code, a target address and, for a program, the data word. The array-side engine that performs the work is outside this block. The only thing it feeds back is `erase_busy`, which is high while a sector erase is running.

Two enumerated registers hold the decoder state. The mode register holds one of `M_READ`, `M_AUTOSEL`, `M_BYPASS`, `M_SECURE`, `M_CFI`, `M_SUSP` or `M_SUSP_AUTOSEL`. The sequence register holds how far a multi-write sequence has advanced:
- `S_IDLE`.
- `S_UNLK1`, after the first key.
- `S_UNLK2`, after the second key, when a command is expected.
- `S_PROG`, when the program address and data are expected.
- `S_ERS1`, `S_ERS2` and `S_ERS3`, the second key pair and the erase selector.
- `S_BYP_PROG` and `S_BYP_RST`, inside bypass.
- `S_SEC_EXIT`, when the zero that leaves the secured region is expected.

Every step in the requirements below is a transition between these states. Any write that does not continue a sequence returns the sequence register to `S_IDLE`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and after any reset pulse, `mode` is 0 and `req_valid` is 0. The mode codes are: 0 read, 1 autoselect, 2 bypass, 3 secured region, 4 CFI, 5 erase-suspended read, 6 autoselect while suspended.
- R2: The unlock handshake is two writes: data AAh at key address 555h, then data 55h at key address 2AAh. Address matching compares only bits 10:0. Data matching compares only bits 7:0.
- R3: After the unlock, writing 90h to 555h moves mode 0 to mode 1 and moves mode 5 to mode 6.
- R4: After the unlock, writing A0h to 555h arms a program. The next write, whatever its value, produces a one-cycle request with op 1, carrying that write's full address and data. The mode does not change. The op codes are: 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume.
- R5: From mode 0, the six-write sequence (unlock, 80h at 555h, unlock, then 10h at 555h) requests op 2 with address 0 and data 0.
- R6: The same sequence ending in 30h at any address requests op 3. The request address keeps bits 19:12 of that write and clears bits 11:0. The request data is 0.
- R7: From mode 0, the unlock followed by 20h at 555h enters mode 2. In mode 2, A0h at any address followed by one more write requests op 1. In mode 2, F0h and 98h have no effect.
- R8: Mode 2 is left only when a write of 90h is followed directly by a write of 00h, which gives mode 0. If 90h is followed by anything else, the decoder stays in mode 2.
- R9: A single write of F0h at any address, outside mode 2, returns mode 6 and mode 5 to mode 5, and returns every other mode to mode 0. No request is issued.
- R10: While `erase_busy` is 1 in mode 0, a write of B0h requests op 4 and enters mode 5. In mode 5, a write of 30h requests op 5 and returns to mode 0. B0h with `erase_busy` at 0, and 30h outside mode 5, are ignored.
- R11: A write of 98h at 055h enters mode 4, but only from mode 0 or mode 1.
- R12: From mode 0, the unlock followed by 88h at 555h enters mode 3. In mode 3, the unlock, then 90h at 555h, then 00h returns to mode 0.
- R13: A write that breaks a sequence in progress leaves the mode as it was, issues no request, and makes the next write start from idle.
- R14: While `erase_busy` is 1, every write whose low byte is not B0h is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | A bus write occurs in this cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data word of the write |
| erase_busy | input | 1 | A sector erase is running in the array engine |
| mode | output | 3 | Current mode code (see R1) |
| req_valid | output | 1 | One-cycle operation request strobe |
| req_op | output | 3 | Operation code (see R4) |
| req_addr | output | ADDR_W | Target address of the request |
| req_data | output | DATA_W | Program data of the request, 0 for other operations |

## Verification
The bench builds the decoder with its defaults: a 20-bit address, a 16-bit data word and the sector field starting at bit 12. This leaves nine address bits above the 11-bit key window. Keys written with those bits set must still match, which exercises aliasing. A sector erase aimed at an address with nonzero low bits shows the clearing of bits 11:0. The 16-bit data width lets commands carry junk in the upper byte, and lets program data pass through intact even when its value is F0h, the reset byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        M_READ         = 3'd0,
        M_AUTOSEL      = 3'd1,
        M_BYPASS       = 3'd2,
        M_SECURE       = 3'd3,
        M_CFI          = 3'd4,
        M_SUSP         = 3'd5,
        M_SUSP_AUTOSEL = 3'd6
    } mode_e;

    typedef enum logic [3:0] {
        S_IDLE, S_UNLK1, S_UNLK2, S_PROG,
        S_ERS1, S_ERS2, S_ERS3,
        S_BYP_PROG, S_BYP_RST, S_SEC_EXIT
    } seq_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_CHIP   = 3'd2,
        OP_SECT   = 3'd3,
        OP_SUSP   = 3'd4,
        OP_RESUME = 3'd5
    } op_e;

    localparam int KEY_W = 11;

    localparam logic [KEY_W-1:0] ADR_KEY1 = 11'h555;
    localparam logic [KEY_W-1:0] ADR_KEY2 = 11'h2AA;
    localparam logic [KEY_W-1:0] ADR_CFI  = 11'h055;

    localparam logic [7:0] CB_KEY1    = 8'hAA;
    localparam logic [7:0] CB_KEY2    = 8'h55;
    localparam logic [7:0] CB_IDENT   = 8'h90;
    localparam logic [7:0] CB_PROG    = 8'hA0;
    localparam logic [7:0] CB_SECURE  = 8'h88;
    localparam logic [7:0] CB_ERASE   = 8'h80;
    localparam logic [7:0] CB_BYPASS  = 8'h20;
    localparam logic [7:0] CB_CHIP    = 8'h10;
    localparam logic [7:0] CB_SECT    = 8'h30;
    localparam logic [7:0] CB_SUSP    = 8'hB0;
    localparam logic [7:0] CB_RESET   = 8'hF0;
    localparam logic [7:0] CB_CFI     = 8'h98;
    localparam logic [7:0] CB_ZERO    = 8'h00;

endpackage

// File: rtl/cmd_match.sv
module cmd_match
    import flash_cmd_pkg::*;
(
    input  logic [KEY_W-1:0] addr_lo,
    input  logic [7:0]       data_lo,
    output logic [7:0]       cmd_byte,
    output logic             at_key1,
    output logic             at_key2,
    output logic             at_cfi
);
    // Only the low address window and the low data byte take part in matching.
    assign cmd_byte = data_lo;
    assign at_key1  = (addr_lo == ADR_KEY1);
    assign at_key2  = (addr_lo == ADR_KEY2);
    assign at_cfi   = (addr_lo == ADR_CFI);
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              erase_busy,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [7:0]        cmd_byte,
    input  logic              at_key1,
    input  logic              at_key2,
    input  logic              at_cfi,
    output mode_e             mode,
    output logic              nxt_valid,
    output op_e               nxt_op,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [DATA_W-1:0] nxt_data
);
    localparam int SECT_W = ADDR_W - SECT_LSB;

    seq_e  seq, seq_n;
    mode_e mode_n, rst_tgt;
    logic  f0_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq  <= S_IDLE;
            mode <= M_READ;
        end else begin
            seq  <= seq_n;
            mode <= mode_n;
        end
    end

    always_comb begin
        seq_n     = seq;
        mode_n    = mode;
        nxt_valid = 1'b0;
        nxt_op    = OP_NONE;
        nxt_addr  = '0;
        nxt_data  = '0;
        rst_tgt   = (mode == M_SUSP || mode == M_SUSP_AUTOSEL) ? M_SUSP : M_READ;
        f0_hit    = (cmd_byte == CB_RESET) && (mode != M_BYPASS);
        if (wr_en) begin
            if (erase_busy) begin
                if (cmd_byte == CB_SUSP && mode == M_READ) begin
                    seq_n     = S_IDLE;
                    mode_n    = M_SUSP;
                    nxt_valid = 1'b1;
                    nxt_op    = OP_SUSP;
                end
            end else begin
                seq_n = S_IDLE;
                unique case (seq)
                    S_IDLE: begin
                        if (mode == M_BYPASS) begin
                            if (cmd_byte == CB_PROG)       seq_n = S_BYP_PROG;
                            else if (cmd_byte == CB_IDENT) seq_n = S_BYP_RST;
                        end else if (f0_hit) begin
                            mode_n = rst_tgt;
                        end else if (cmd_byte == CB_CFI && at_cfi &&
                                     (mode == M_READ || mode == M_AUTOSEL)) begin
                            mode_n = M_CFI;
                        end else if (cmd_byte == CB_SECT && mode == M_SUSP) begin
                            mode_n    = M_READ;
                            nxt_valid = 1'b1;
                            nxt_op    = OP_RESUME;
                        end else if (cmd_byte == CB_KEY1 && at_key1 &&
                                     (mode == M_READ || mode == M_SUSP || mode == M_SECURE)) begin
                            seq_n = S_UNLK1;
                        end
                    end
                    S_UNLK1: begin
                        if (cmd_byte == CB_KEY2 && at_key2) seq_n  = S_UNLK2;
                        else if (f0_hit)                    mode_n = rst_tgt;
                    end
                    S_UNLK2: begin
                        if (f0_hit) begin
                            mode_n = rst_tgt;
                        end else if (at_key1) begin
                            if (cmd_byte == CB_PROG) begin
                                seq_n = S_PROG;
                            end else if (cmd_byte == CB_IDENT) begin
                                if (mode == M_READ)      mode_n = M_AUTOSEL;
                                else if (mode == M_SUSP) mode_n = M_SUSP_AUTOSEL;
                                else                     seq_n  = S_SEC_EXIT;
                            end else if (mode == M_READ) begin
                                if (cmd_byte == CB_SECURE)      mode_n = M_SECURE;
                                else if (cmd_byte == CB_ERASE)  seq_n  = S_ERS1;
                                else if (cmd_byte == CB_BYPASS) mode_n = M_BYPASS;
                            end
                        end
                    end
                    S_PROG, S_BYP_PROG: begin
                        nxt_valid = 1'b1;
                        nxt_op    = OP_PROG;
                        nxt_addr  = wr_addr;
                        nxt_data  = wr_data;
                    end
                    S_ERS1: begin
                        if (cmd_byte == CB_KEY1 && at_key1) seq_n  = S_ERS2;
                        else if (f0_hit)                    mode_n = rst_tgt;
                    end
                    S_ERS2: begin
                        if (cmd_byte == CB_KEY2 && at_key2) seq_n  = S_ERS3;
                        else if (f0_hit)                    mode_n = rst_tgt;
                    end
                    S_ERS3: begin
                        if (cmd_byte == CB_CHIP && at_key1) begin
                            nxt_valid = 1'b1;
                            nxt_op    = OP_CHIP;
                        end else if (cmd_byte == CB_SECT) begin
                            nxt_valid = 1'b1;
                            nxt_op    = OP_SECT;
                            nxt_addr  = {wr_addr[ADDR_W-1:SECT_LSB], {SECT_LSB{1'b0}}};
                        end else if (f0_hit) begin
                            mode_n = rst_tgt;
                        end
                    end
                    S_BYP_RST: begin
                        if (cmd_byte == CB_ZERO) mode_n = M_READ;
                    end
                    S_SEC_EXIT: begin
                        if (cmd_byte == CB_ZERO || f0_hit) mode_n = M_READ;
                    end
                    default: seq_n = S_IDLE;
                endcase
            end
        end
    end

    logic [SECT_W-1:0] unused_sect_w;
    assign unused_sect_w = '0;
endmodule

// File: rtl/req_reg.sv
module req_reg
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nxt_valid,
    input  op_e               nxt_op,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic [DATA_W-1:0] nxt_data,
    output logic              req_valid,
    output op_e               req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_op    <= OP_NONE;
            req_addr  <= '0;
            req_data  <= '0;
        end else begin
            req_valid <= nxt_valid;
            req_op    <= nxt_op;
            req_addr  <= nxt_addr;
            req_data  <= nxt_data;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              erase_busy,
    output logic [2:0]        mode,
    output logic              req_valid,
    output logic [2:0]        req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data
);
    logic [7:0]        cmd_byte;
    logic              at_key1, at_key2, at_cfi;
    mode_e             mode_q;
    logic              nxt_valid;
    op_e               nxt_op, op_q;
    logic [ADDR_W-1:0] nxt_addr;
    logic [DATA_W-1:0] nxt_data;

    cmd_match u_match (
        .addr_lo  (wr_addr[KEY_W-1:0]),
        .data_lo  (wr_data[7:0]),
        .cmd_byte (cmd_byte),
        .at_key1  (at_key1),
        .at_key2  (at_key2),
        .at_cfi   (at_cfi)
    );

    cmd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .erase_busy (erase_busy),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cmd_byte   (cmd_byte),
        .at_key1    (at_key1),
        .at_key2    (at_key2),
        .at_cfi     (at_cfi),
        .mode       (mode_q),
        .nxt_valid  (nxt_valid),
        .nxt_op     (nxt_op),
        .nxt_addr   (nxt_addr),
        .nxt_data   (nxt_data)
    );

    req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_valid (nxt_valid),
        .nxt_op    (nxt_op),
        .nxt_addr  (nxt_addr),
        .nxt_data  (nxt_data),
        .req_valid (req_valid),
        .req_op    (op_q),
        .req_addr  (req_addr),
        .req_data  (req_data)
    );

    assign mode   = mode_q;
    assign req_op = op_q;
endmodule

// File: rtl/flash_cmd_sva.sv
module flash_cmd_sva
    import flash_cmd_pkg::*;
#(
    parameter int SECT_LSB = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [7:0]          cmd_byte,
    input logic                erase_busy,
    input logic [2:0]          mode,
    input logic                req_valid,
    input logic [2:0]          req_op,
    input logic [SECT_LSB-1:0] req_addr_lo
);
    // R4: a request only follows a write cycle
    a_r4_req_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(wr_en));

    // R4: a request always carries a real operation code
    a_r4_req_has_op: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_op != OP_NONE));

    // R6: a sector request carries a sector-aligned address
    a_r6_sector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_SECT) |-> (req_addr_lo == '0));

    // R8: leaving bypass needs a write of zero
    a_r8_bypass_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == M_BYPASS && mode != M_BYPASS) |->
            ($past(wr_en) && $past(cmd_byte) == CB_ZERO));

    // R10: resume only from the suspended mode, suspend only while erasing
    a_r10_resume_src: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_RESUME) |-> ($past(mode) == M_SUSP));
    a_r10_suspend_src: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_SUSP) |-> $past(erase_busy));

    // R14: writes other than suspend are ignored while erasing
    a_r14_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && wr_en && cmd_byte != CB_SUSP) |=> ($stable(mode) && !req_valid));
endmodule

bind flash_cmd_decoder flash_cmd_sva #(.SECT_LSB(SECT_LSB)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .cmd_byte    (wr_data[7:0]),
    .erase_busy  (erase_busy),
    .mode        (mode),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr_lo (req_addr[SECT_LSB-1:0])
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int NV     = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              erase_busy = 1'b0;
    logic [2:0]        mode;
    logic              req_valid;
    logic [2:0]        req_op;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(12)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .erase_busy(erase_busy), .mode(mode),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data)
    );

    // {addr, data, busy, exp mode, exp valid, exp op, exp addr, exp data, req tag}
    localparam logic [83:0] TBL [0:NV-1] = '{
        {20'h00555,16'h00AA,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd2},  // R2 key 1
        {20'h002AA,16'h0055,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd2},  // R2 key 2
        {20'h00555,16'h0090,1'b0,3'd1,1'b0,3'd0,20'h00000,16'h0000,4'd3},  // R3 autoselect
        {20'h00055,16'h0098,1'b0,3'd4,1'b0,3'd0,20'h00000,16'h0000,4'd11}, // R11 CFI from autoselect
        {20'h00000,16'h00F0,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd9},  // R9 reset
        {20'h7F555,16'hFFAA,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd2},  // R2 aliased key
        {20'h3A2AA,16'h1255,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd2},
        {20'h80555,16'h00A0,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd4},  // R4 arm
        {20'h00010,16'h00F0,1'b0,3'd0,1'b1,3'd1,20'h00010,16'h00F0,4'd4},  // R4 program F0 data
        {20'h00555,16'h00AA,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd5},  // R5 chip erase
        {20'h002AA,16'h0055,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd5},
        {20'h00555,16'h0080,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd5},
        {20'h00555,16'h00AA,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd5},
        {20'h002AA,16'h0055,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd5},
        {20'h00555,16'h0010,1'b0,3'd0,1'b1,3'd2,20'h00000,16'h0000,4'd5},
        {20'h00555,16'h00AA,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd6},  // R6 sector erase
        {20'h002AA,16'h0055,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd6},
        {20'h00555,16'h0080,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd6},
        {20'h00555,16'h00AA,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd6},
        {20'h002AA,16'h0055,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd6},
        {20'h5A7FF,16'h0030,1'b0,3'd0,1'b1,3'd3,20'h5A000,16'h0000,4'd6},
        {20'h00555,16'h00AA,1'b1,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd14}, // R14 busy ignore
        {20'h00000,16'h00B0,1'b1,3'd5,1'b1,3'd4,20'h00000,16'h0000,4'd10}, // R10 suspend
        {20'h00555,16'h00AA,1'b0,3'd5,1'b0,3'd0,20'h00000,16'h0000,4'd3},
        {20'h002AA,16'h0055,1'b0,3'd5,1'b0,3'd0,20'h00000,16'h0000,4'd3},
        {20'h00555,16'h0090,1'b0,3'd6,1'b0,3'd0,20'h00000,16'h0000,4'd3},  // R3 suspended autoselect
        {20'h00000,16'h00F0,1'b0,3'd5,1'b0,3'd0,20'h00000,16'h0000,4'd9},  // R9 back to suspend
        {20'h00555,16'h00AA,1'b0,3'd5,1'b0,3'd0,20'h00000,16'h0000,4'd4},
        {20'h002AA,16'h0055,1'b0,3'd5,1'b0,3'd0,20'h00000,16'h0000,4'd4},
        {20'h00555,16'h00A0,1'b0,3'd5,1'b0,3'd0,20'h00000,16'h0000,4'd4},
        {20'h0ABCD,16'h5A5A,1'b0,3'd5,1'b1,3'd1,20'h0ABCD,16'h5A5A,4'd4},  // R4 program in suspend
        {20'h00000,16'h0030,1'b0,3'd0,1'b1,3'd5,20'h00000,16'h0000,4'd10}, // R10 resume
        {20'h00000,16'h00B0,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd10}, // R10 suspend refused
        {20'h00000,16'h0030,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd10}, // R10 resume refused
        {20'h00555,16'h00AA,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd7},
        {20'h002AA,16'h0055,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd7},
        {20'h00555,16'h0020,1'b0,3'd2,1'b0,3'd0,20'h00000,16'h0000,4'd7},  // R7 bypass
        {20'h00000,16'h00F0,1'b0,3'd2,1'b0,3'd0,20'h00000,16'h0000,4'd7},  // R7 F0 no effect
        {20'h00055,16'h0098,1'b0,3'd2,1'b0,3'd0,20'h00000,16'h0000,4'd7},  // R7 CFI no effect
        {20'h00777,16'h00A0,1'b0,3'd2,1'b0,3'd0,20'h00000,16'h0000,4'd7},
        {20'h04444,16'h1234,1'b0,3'd2,1'b1,3'd1,20'h04444,16'h1234,4'd7},
        {20'h00000,16'h0090,1'b0,3'd2,1'b0,3'd0,20'h00000,16'h0000,4'd8},
        {20'h00000,16'h0011,1'b0,3'd2,1'b0,3'd0,20'h00000,16'h0000,4'd8},  // R8 broken exit
        {20'h00000,16'h0090,1'b0,3'd2,1'b0,3'd0,20'h00000,16'h0000,4'd8},
        {20'h00000,16'h0000,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd8},  // R8 exit
        {20'h00555,16'h00AA,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd13},
        {20'h002AB,16'h0055,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd13}, // R13 wrong key addr
        {20'h00555,16'h0090,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd13}, // R13 restart from idle
        {20'h00555,16'h00AA,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd12},
        {20'h002AA,16'h0055,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd12},
        {20'h00555,16'h0088,1'b0,3'd3,1'b0,3'd0,20'h00000,16'h0000,4'd12}, // R12 secured
        {20'h00555,16'h00AA,1'b0,3'd3,1'b0,3'd0,20'h00000,16'h0000,4'd13},
        {20'h002AA,16'h0055,1'b0,3'd3,1'b0,3'd0,20'h00000,16'h0000,4'd13},
        {20'h00555,16'h0077,1'b0,3'd3,1'b0,3'd0,20'h00000,16'h0000,4'd13}, // R13 keeps secured
        {20'h00555,16'h00AA,1'b0,3'd3,1'b0,3'd0,20'h00000,16'h0000,4'd12},
        {20'h002AA,16'h0055,1'b0,3'd3,1'b0,3'd0,20'h00000,16'h0000,4'd12},
        {20'h00555,16'h0090,1'b0,3'd3,1'b0,3'd0,20'h00000,16'h0000,4'd12},
        {20'h00000,16'h0000,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd12}, // R12 exit
        {20'h00555,16'h00AA,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd13},
        {20'h002AA,16'h0055,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd13},
        {20'h00555,16'h0080,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd13},
        {20'h00555,16'h00AA,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd13},
        {20'h002AA,16'h0055,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd13},
        {20'h00555,16'h0044,1'b0,3'd0,1'b0,3'd0,20'h00000,16'h0000,4'd13}  // R13 bad erase selector
    };

    task automatic check(input int tag, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic b);
        wr_en      = 1'b1;
        wr_addr    = a;
        wr_data    = d;
        erase_busy = b;
        @(negedge clk);
        wr_en      = 1'b0;
        erase_busy = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, "mode at reset", 32'(mode), 32'd0);
        check(1, "valid at reset", 32'(req_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [83:0] e;
            e = TBL[i];
            do_wr(e[83:64], e[63:48], e[47]);
            check(int'(e[3:0]), "mode", 32'(mode), 32'(e[46:44]));
            check(int'(e[3:0]), "req_valid", 32'(req_valid), 32'(e[43]));
            if (e[43]) begin
                check(int'(e[3:0]), "req_op", 32'(req_op), 32'(e[42:40]));
                check(int'(e[3:0]), "req_addr", 32'(req_addr), 32'(e[39:20]));
                check(int'(e[3:0]), "req_data", 32'(req_data), 32'(e[19:4]));
            end
        end

        // R4: request lasts one cycle only
        do_wr(20'h00555, 16'h00AA, 1'b0);
        do_wr(20'h002AA, 16'h0055, 1'b0);
        do_wr(20'h00555, 16'h00A0, 1'b0);
        do_wr(20'h00123, 16'hC0DE, 1'b0);
        check(4, "pulse high", 32'(req_valid), 32'd1);
        @(negedge clk);
        check(4, "pulse low next cycle", 32'(req_valid), 32'd0);

        // R11: CFI from read mode, wrong address refused
        do_wr(20'h00555, 16'h0098, 1'b0);
        check(11, "CFI wrong address", 32'(mode), 32'd0);
        do_wr(20'h00055, 16'h0098, 1'b0);
        check(11, "CFI from read", 32'(mode), 32'd4);
        do_wr(20'h00000, 16'h00F0, 1'b0);
        check(9, "reset from CFI", 32'(mode), 32'd0);

        // R1: reset pulse from autoselect
        do_wr(20'h00555, 16'h00AA, 1'b0);
        do_wr(20'h002AA, 16'h0055, 1'b0);
        do_wr(20'h00555, 16'h0090, 1'b0);
        check(3, "autoselect before reset", 32'(mode), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, "mode after reset pulse", 32'(mode), 32'd0);
        check(1, "valid after reset pulse", 32'(req_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule